// File: doc/BRIEF.md
# Perturb-and-Observe Tracker with Stage-Mode Sequencer

This block produces the set-points for a two-stage photovoltaic converter. Samples of panel voltage, panel power and grid RMS voltage arrive on a valid/ready stream. The block pulls exactly one sample from that stream at start-up, and then one per disturbance period. The first sample after a start strobe seeds the panel voltage reference from the open-circuit voltage. Each later sample drives one perturb-and-observe step of fixed size.

The same sample also chooses the operating mode. Below the rated panel voltage, the block runs in two-stage mode: the boost is on, and the bus reference follows the grid RMS voltage scaled by 1.5625 and clamped. At or above the rated voltage, the boost is off and the tracked reference becomes the bus reference. A hysteresis band keeps the mode from chattering.

All arithmetic is integer with 1 V per LSB. The period length is a run-time tick count. With a 50 MHz clock, 100,000,000 ticks give a 2 s period.

Back-pressure rules are as follows. `s_ready` is high only while the block is waiting for a sample. It stays low in every other state. The producer holds `s_valid` and its data stable until a cycle in which both `s_valid` and `s_ready` are high; that cycle is the transfer. A sample that is not transferred has no effect on any output.

Top module: `mppt_seq`

## Requirements
- R1: After reset, `v_ref`, `bus_ref`, `boost_en` and `single_stage` are 0. Until the first start strobe, `s_ready` stays 0 and offered samples change no output.
- R2: The first transfer after a start strobe sets `v_ref` to the panel voltage clamped to 150..450 V and the search direction to downward. It sets `single_stage` to 1 exactly when the panel voltage is at least 360 V.
- R3: After each transfer, `s_ready` is 0 for max(P,1) clock cycles, where P is `period_ticks`. It is then 1 until the next transfer.
- R4: A transfer after the period moves `v_ref` by 5 V. The step keeps its last direction if the new power is greater than or equal to the previous sample's power. It reverses if the new power is lower.
- R5: If a step would land at or beyond 450 V, `v_ref` becomes 450 and the next direction is downward. If a step would land at or below 150 V, `v_ref` becomes 150 and the next direction is upward. `v_ref` always stays within 150..450 once set.
- R6: During tracking, two-stage mode switches to single-stage when the panel voltage is at least 365 V. Single-stage mode returns to two-stage when the panel voltage is below 355 V. Between those thresholds the mode holds.
- R7: In two-stage mode (`single_stage`=0 after the first transfer), `boost_en` is 1. `bus_ref` is floor(grid×200/128) clamped to 360..450.
- R8: In single-stage mode, `boost_en` is 0 and `bus_ref` equals `v_ref`.
- R9: A start strobe at any time abandons the current period. The next offered sample is transferred at once and handled as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start / restart strobe |
| period_ticks | input | 28 | Disturbance period in clock cycles |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready |
| s_pv_volt | input | 12 | Panel voltage, 1 V/LSB |
| s_pv_power | input | 20 | Panel power, 1 W/LSB |
| s_grid_rms | input | 12 | Grid RMS voltage, 1 V/LSB |
| v_ref | output | 12 | Panel voltage reference |
| bus_ref | output | 12 | Bus voltage reference |
| boost_en | output | 1 | Boost stage enable |
| single_stage | output | 1 | 1 = single-stage mode |

## Verification
The bench builds the block with its default window, step and threshold parameters. It sets the period to 0, 1, 2, 3 and 5 ticks, so hundreds of perturbation decisions fit in a short run. It feeds back a concave power curve with the peak placed inside the window, beyond the upper edge and below the lower edge, so it reaches steady dithering, upper saturation and lower saturation. Panel voltages are stepped across the hysteresis thresholds, and the grid RMS is swept from 100 V to 350 V so both bus clamps and the linear region are covered.

// File: rtl/mppt_seq_pkg.sv
package mppt_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DEC  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/mppt_period_timer.sv
module mppt_period_timer #(
  parameter int CW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] period,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  assign expired = run && ((cnt_q + CW'(1)) >= period);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || expired) cnt_q <= '0;
    else                      cnt_q <= cnt_q + CW'(1);
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && period != '0) |-> (cnt_q < period));
endmodule

// File: rtl/mppt_po_step.sv
module mppt_po_step #(
  parameter int VW     = 12,
  parameter int PW     = 20,
  parameter int V_MIN  = 150,
  parameter int V_MAX  = 450,
  parameter int V_STEP = 5
) (
  input  logic [VW-1:0] v_cur,
  input  logic          dir_up,
  input  logic [PW-1:0] p_new,
  input  logic [PW-1:0] p_old,
  output logic [VW-1:0] v_next,
  output logic          dir_next
);
  localparam int EW = VW + 2;
  localparam logic signed [EW-1:0] S_STEP = EW'(V_STEP);
  localparam logic signed [EW-1:0] S_MIN  = EW'(V_MIN);
  localparam logic signed [EW-1:0] S_MAX  = EW'(V_MAX);

  logic                 keep_dir;
  logic signed [EW-1:0] base;
  logic signed [EW-1:0] cand;

  always_comb begin
    keep_dir = (p_new < p_old) ? ~dir_up : dir_up;
    base     = $signed({2'b00, v_cur});
    cand     = keep_dir ? (base + S_STEP) : (base - S_STEP);
    if (cand >= S_MAX) begin
      v_next   = VW'(V_MAX);
      dir_next = 1'b0;
    end else if (cand <= S_MIN) begin
      v_next   = VW'(V_MIN);
      dir_next = 1'b1;
    end else begin
      v_next   = cand[VW-1:0];
      dir_next = keep_dir;
    end
  end
endmodule

// File: rtl/mppt_mode_sel.sv
module mppt_mode_sel #(
  parameter int VW        = 12,
  parameter int GW        = 12,
  parameter int V_RATED   = 360,
  parameter int V_HYST    = 5,
  parameter int BUS_NUM   = 200,
  parameter int BUS_SHIFT = 7,
  parameter int BUS_MIN   = 360,
  parameter int BUS_MAX   = 450
) (
  input  logic [VW-1:0] pv_volt,
  input  logic [GW-1:0] grid_rms,
  input  logic [VW-1:0] v_new,
  input  logic          cur_single,
  input  logic          fresh,
  output logic          single_next,
  output logic [VW-1:0] bus_next
);
  localparam int MW    = $clog2(BUS_NUM + 1);
  localparam int XW    = GW + MW;
  localparam int UP_TH = V_RATED + V_HYST;
  localparam int DN_TH = V_RATED - V_HYST;

  logic [XW-1:0] scaled;
  logic [VW-1:0] bus_two;

  always_comb begin
    if (fresh)           single_next = (pv_volt >= VW'(V_RATED));
    else if (cur_single) single_next = !(pv_volt < VW'(DN_TH));
    else                 single_next = (pv_volt >= VW'(UP_TH));
  end

  always_comb begin
    scaled = (XW'(grid_rms) * XW'(BUS_NUM)) >> BUS_SHIFT;
    if (scaled < XW'(BUS_MIN))      bus_two = VW'(BUS_MIN);
    else if (scaled > XW'(BUS_MAX)) bus_two = VW'(BUS_MAX);
    else                            bus_two = scaled[VW-1:0];
    bus_next = single_next ? v_new : bus_two;
  end
endmodule

// File: rtl/mppt_seq.sv
module mppt_seq
  import mppt_seq_pkg::*;
#(
  parameter int VW        = 12,
  parameter int PW        = 20,
  parameter int GW        = 12,
  parameter int CW        = 28,
  parameter int V_MIN     = 150,
  parameter int V_MAX     = 450,
  parameter int V_STEP    = 5,
  parameter int V_RATED   = 360,
  parameter int V_HYST    = 5,
  parameter int BUS_NUM   = 200,
  parameter int BUS_SHIFT = 7,
  parameter int BUS_MIN   = 360,
  parameter int BUS_MAX   = 450
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] period_ticks,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [VW-1:0] s_pv_volt,
  input  logic [PW-1:0] s_pv_power,
  input  logic [GW-1:0] s_grid_rms,
  output logic [VW-1:0] v_ref,
  output logic [VW-1:0] bus_ref,
  output logic          boost_en,
  output logic          single_stage
);
  localparam int UP_TH = V_RATED + V_HYST;
  localparam int DN_TH = V_RATED - V_HYST;

  seq_state_e    state_q;
  logic [VW-1:0] v_ref_q, bus_q;
  logic [PW-1:0] p_prev_q;
  logic          dir_q, single_q, live_q;

  logic          acc, fresh, expired;
  logic [VW-1:0] v_acq, v_step, v_new, bus_new;
  logic          dir_step, dir_new, single_new;

  assign s_ready = ((state_q == ST_ACQ) || (state_q == ST_DEC)) && !start;
  assign acc     = s_valid && s_ready;
  assign fresh   = (state_q == ST_ACQ);

  mppt_period_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_WAIT),
    .period(period_ticks), .expired(expired)
  );

  mppt_po_step #(
    .VW(VW), .PW(PW), .V_MIN(V_MIN), .V_MAX(V_MAX), .V_STEP(V_STEP)
  ) u_step (
    .v_cur(v_ref_q), .dir_up(dir_q), .p_new(s_pv_power), .p_old(p_prev_q),
    .v_next(v_step), .dir_next(dir_step)
  );

  always_comb begin
    if (s_pv_volt < VW'(V_MIN))      v_acq = VW'(V_MIN);
    else if (s_pv_volt > VW'(V_MAX)) v_acq = VW'(V_MAX);
    else                             v_acq = s_pv_volt;
    v_new   = fresh ? v_acq : v_step;
    dir_new = fresh ? 1'b0  : dir_step;
  end

  mppt_mode_sel #(
    .VW(VW), .GW(GW), .V_RATED(V_RATED), .V_HYST(V_HYST),
    .BUS_NUM(BUS_NUM), .BUS_SHIFT(BUS_SHIFT), .BUS_MIN(BUS_MIN), .BUS_MAX(BUS_MAX)
  ) u_mode (
    .pv_volt(s_pv_volt), .grid_rms(s_grid_rms), .v_new(v_new),
    .cur_single(single_q), .fresh(fresh),
    .single_next(single_new), .bus_next(bus_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (start) begin
      state_q <= ST_ACQ;
    end else begin
      case (state_q)
        ST_ACQ:  if (acc)     state_q <= ST_WAIT;
        ST_WAIT: if (expired) state_q <= ST_DEC;
        ST_DEC:  if (acc)     state_q <= ST_WAIT;
        default:              state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_ref_q  <= '0;
      bus_q    <= '0;
      p_prev_q <= '0;
      dir_q    <= 1'b0;
      single_q <= 1'b0;
      live_q   <= 1'b0;
    end else if (acc) begin
      v_ref_q  <= v_new;
      bus_q    <= bus_new;
      p_prev_q <= s_pv_power;
      dir_q    <= dir_new;
      single_q <= single_new;
      live_q   <= 1'b1;
    end
  end

  assign v_ref        = v_ref_q;
  assign bus_ref      = bus_q;
  assign boost_en     = live_q && !single_q;
  assign single_stage = single_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live_q |-> (!boost_en && bus_ref == '0 && v_ref == '0));
  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !s_ready);
  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && state_q == ST_DEC) |=>
      ((v_ref_q <= $past(v_ref_q) + VW'(V_STEP)) &&
       ($past(v_ref_q) <= v_ref_q + VW'(V_STEP))));
  // R5
  ref_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (v_ref_q >= VW'(V_MIN) && v_ref_q <= VW'(V_MAX)));
  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && state_q == ST_DEC && s_pv_volt >= VW'(DN_TH) && s_pv_volt < VW'(UP_TH))
      |=> (single_q == $past(single_q)));
  // R7
  two_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !single_q) |-> (bus_q >= VW'(BUS_MIN) && bus_q <= VW'(BUS_MAX)));
  // R8
  single_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && single_q) |-> (bus_q == v_ref_q && !boost_en));
endmodule

// File: tb/mppt_seq_bench.sv
module mppt_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [27:0] period_ticks = 28'd3;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_pv_volt = '0;
  logic [19:0] s_pv_power = '0;
  logic [11:0] s_grid_rms = '0;
  logic [11:0] v_ref, bus_ref;
  logic        boost_en, single_stage;

  int n_cmp = 0;
  int n_bad = 0;
  int m_v = 0, m_dir = 0, m_prev = 0, m_single = 0, m_g = 0;

  always #10 clk = ~clk;

  mppt_seq u_mppt_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .period_ticks(period_ticks),
    .s_valid(s_valid), .s_ready(s_ready), .s_pv_volt(s_pv_volt),
    .s_pv_power(s_pv_power), .s_grid_rms(s_grid_rms),
    .v_ref(v_ref), .bus_ref(bus_ref), .boost_en(boost_en),
    .single_stage(single_stage)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampi(input int x, input int lo, input int hi);
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  function automatic int pcurve(input int v, input int mpp);
    int d = v - mpp;
    int p = 200000 - d * d;
    return (p < 0) ? 0 : p;
  endfunction

  task automatic check_outs(input string tag);
    chk({tag, " R4 R5 v_ref"}, int'(v_ref), m_v);
    chk({tag, " R6 single_stage"}, int'(single_stage), m_single);
    if (m_single != 0) begin
      chk({tag, " R8 bus_ref"}, int'(bus_ref), m_v);
      chk({tag, " R8 boost_en"}, int'(boost_en), 0);
    end else begin
      chk({tag, " R7 bus_ref"}, int'(bus_ref), clampi((m_g * 200) / 128, 360, 450));
      chk({tag, " R7 boost_en"}, int'(boost_en), 1);
    end
  endtask

  task automatic xfer(input int v, input int p, input int g, output int waits);
    @(negedge clk);
    s_valid = 1'b1; s_pv_volt = 12'(v); s_pv_power = 20'(p); s_grid_rms = 12'(g);
    waits = 0;
    while (!s_ready) begin
      @(negedge clk);
      waits++;
    end
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic acquire(input int v, input int p, input int g);
    int w;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    xfer(v, p, g, w);
    chk("R9 restart wait", w, 0);
    m_v = clampi(v, 150, 450); m_dir = 0; m_prev = p; m_g = g;
    m_single = (v >= 360) ? 1 : 0;
    check_outs("R2 acquire");
  endtask

  task automatic decide(input int v, input int p, input int g);
    int w, d, cand;
    xfer(v, p, g, w);
    chk("R3 period wait", w, (period_ticks <= 1) ? 0 : int'(period_ticks) - 1);
    d = (p < m_prev) ? 1 - m_dir : m_dir;
    cand = m_v + ((d != 0) ? 5 : -5);
    if (cand >= 450) begin m_v = 450; m_dir = 0; end
    else if (cand <= 150) begin m_v = 150; m_dir = 1; end
    else begin m_v = cand; m_dir = d; end
    if (m_single != 0 && v < 355) m_single = 0;
    else if (m_single == 0 && v >= 365) m_single = 1;
    m_prev = p; m_g = g;
    check_outs("decide");
  endtask

  task automatic track(input int mpp, input int g, input int n);
    for (int i = 0; i < n; i++) decide(m_v, pcurve(m_v, mpp), g);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset v_ref", int'(v_ref), 0);
    chk("R1 reset bus_ref", int'(bus_ref), 0);
    chk("R1 reset boost_en", int'(boost_en), 0);
    chk("R1 reset single", int'(single_stage), 0);
    // R1: samples offered before any start are not taken
    s_valid = 1'b1; s_pv_volt = 12'd300; s_pv_power = 20'd500; s_grid_rms = 12'd250;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 idle s_ready", int'(s_ready), 0);
    end
    chk("R1 idle v_ref", int'(v_ref), 0);
    chk("R1 idle boost_en", int'(boost_en), 0);
    s_valid = 1'b0;

    // R2/R4/R6: start above window, descend through thresholds
    period_ticks = 28'd3;
    acquire(500, 1000, 250);
    track(300, 250, 50);

    // R5 upper edge with R7 upper bus clamp
    period_ticks = 28'd1;
    acquire(100, 1000, 300);
    track(470, 300, 70);

    // R5 lower edge with R7 lower bus clamp, zero period
    period_ticks = 28'd0;
    acquire(200, 1000, 230);
    track(100, 230, 20);

    // R6 hysteresis walk, equal power keeps direction (R4)
    period_ticks = 28'd2;
    acquire(350, 1000, 250);
    decide(362, 1000, 250);
    decide(364, 1000, 250);
    decide(365, 1000, 250);
    decide(358, 1000, 250);
    decide(356, 1000, 250);
    decide(355, 1000, 250);
    decide(354, 1000, 250);
    decide(370, 1000, 250);
    decide(300, 1000, 250);

    // R7 grid sweep in two-stage mode
    for (int g = 100; g <= 350; g += 10) decide(200, 1000, g);

    // R9 restart in the middle of a long period
    period_ticks = 28'd5;
    acquire(400, 2000, 250);
    decide(400, 2100, 250);
    acquire(250, 500, 260);
    decide(250, 400, 260);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule